// File: doc/BRIEF.md
# Quadrature Sine Tone Synthesizer

This block generates a pair of quadrature tones, a sine and a cosine, from a phase that steps by a programmable amount once per sample strobe. The phase register is 21 bits wide and wraps naturally. When the strobe runs at 48 kHz, the tone frequency is `step × 48000 / 2^21` Hz. Only the top ten phase bits address the waveform. A quarter-wave amplitude table holds 257 points, and the other three quadrants and the cosine are found by reflecting and negating into that table.

The requested step is watched on every clock. Whenever its value differs from the value on the clock before, a load pulse copies it into the working step register, so the caller never has to raise a separate write strobe. Each strobe takes the current phase for a sample and then advances the phase. The new sample pair appears two clocks after the strobe edge and is flagged by a one-cycle ready pulse. Between pulses the outputs hold their value.

Top module: `qdds_core`

## Requirements
- R1: While reset is held and right after it, `ready_o` is 0 and both `sine_o` and `cosine_o` read 0.
- R2: A `tick_i` sampled high at clock edge k gives `ready_o` = 1 for exactly the cycle between edges k+1 and k+2. The new sample pair is present on the outputs from edge k+1.
- R3: With `tick_i` low the phase does not move. `sine_o` and `cosine_o` change only at an edge that raises `ready_o`.
- R4: The first sample after reset is taken at phase 0: `sine_o` = 0 and `cosine_o` = 524287 (0x7FFFF).
- R5: For sample n (counting from 0 after reset with a constant step S), let P = (n·S) mod 2^21 and i = P >> 11 (10 bits). The outputs are round(524287·sin(2πi/1024)) and round(524287·cos(2πi/1024)) in 20-bit two's complement, within one LSB.
- R6: A new `step_i` value seen at an edge is loaded at that edge. A strobe at that same edge still advances by the old step, and every later strobe uses the new step.
- R7: Only `step_i[20:0]` affects the phase. Bits 31..21 have no effect, and the phase wraps modulo 2^21.
- R8: `can_accept_o` is 1 in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Sample-rate strobe, one cycle wide |
| step_i | input | 32 | Requested phase step per sample |
| can_accept_o | output | 1 | Always 1; the block never stalls |
| ready_o | output | 1 | One-cycle pulse marking a fresh sample pair |
| sine_o | output | 20 | Sine sample, two's complement |
| cosine_o | output | 20 | Cosine sample, two's complement |

## Verification
On every cycle the assertions check four things. They check the strobe-to-valid-to-ready chain. They check that the phase and outputs hold when no strobe or ready is present. They check that the step register moves only on a load pulse and then takes the requested value. They check that no output reaches the negative code that has no positive counterpart. The amplitude values themselves can only be shown by the bench's scenarios. The same holds for the phase-0 start, the quadrant folding, wrap-around, ignoring of the upper step bits, and the precise sample at which a step change takes effect. The bench compares these against an independent floating-point model of the tone.

// File: rtl/qdds_pkg.sv
package qdds_pkg;

  // Rounded quarter-wave amplitude for point k of qn points (k = 0..qn).
  function automatic int quarter_amp(input int k, input int qn, input int out_w);
    real amp;
    real r;
    amp = (2.0 ** (out_w - 1)) - 1.0;
    r = amp * $sin(1.5707963267948966 * k / qn);
    return $rtoi(r + 0.5);
  endfunction

endpackage

// File: rtl/qdds_step_reg.sv
module qdds_step_reg #(
  parameter int IN_W = 32,
  parameter int PH_W = 21
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [IN_W-1:0] step_i,
  output logic [PH_W-1:0] step_q,
  output logic            load_o
);
  logic [IN_W-1:0] step_prev;

  assign load_o = (step_i != step_prev);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      step_prev <= '0;
      step_q    <= '0;
    end else begin
      step_prev <= step_i;
      if (load_o) step_q <= step_i[PH_W-1:0];
    end
  end

  AST_STEP_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_o |=> $stable(step_q)); // R6
  AST_STEP_TAKE: assert property (@(posedge clk_i) disable iff (rst_i)
    load_o |=> (step_q == $past(step_i[PH_W-1:0]))); // R6
endmodule

// File: rtl/qdds_phase_acc.sv
module qdds_phase_acc #(
  parameter int PH_W = 21,
  parameter int AW   = 10
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            tick_i,
  input  logic [PH_W-1:0] step_i,
  output logic [AW-1:0]   addr_o,
  output logic            vld_o
);
  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= '0;
      addr_o  <= '0;
      vld_o   <= 1'b0;
    end else begin
      vld_o <= tick_i;
      if (tick_i) begin
        addr_o  <= phase_q[PH_W-1 -: AW];
        phase_q <= phase_q + step_i;
      end
    end
  end

  AST_PHASE_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> $stable(phase_q)); // R3
  AST_TICK_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_i |=> vld_o); // R2
endmodule

// File: rtl/qdds_wave_lut.sv
module qdds_wave_lut
  import qdds_pkg::*;
#(
  parameter int AW    = 10,
  parameter int OUT_W = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic [AW-1:0]           addr_i,
  input  logic                    vld_i,
  output logic signed [OUT_W-1:0] sine_o,
  output logic signed [OUT_W-1:0] cosine_o,
  output logic                    ready_o
);
  localparam int QN = 1 << (AW - 2);
  typedef logic [QN:0][OUT_W-1:0] qtab_t;

  function automatic qtab_t build_tab();
    qtab_t t;
    for (int k = 0; k <= QN; k++) t[k] = OUT_W'(quarter_amp(k, QN, OUT_W));
    return t;
  endfunction

  localparam qtab_t QTAB = build_tab();

  function automatic logic signed [OUT_W-1:0] fold(input logic [AW-1:0] idx);
    logic [1:0]      quad;
    int              off;
    logic [OUT_W-1:0] mag;
    quad = idx[AW-1:AW-2];
    off  = int'(idx[AW-3:0]);
    mag  = quad[0] ? QTAB[QN - off] : QTAB[off];
    return quad[1] ? -$signed(mag) : $signed(mag);
  endfunction

  logic [AW-1:0] cos_idx;
  assign cos_idx = addr_i + AW'(QN);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sine_o   <= '0;
      cosine_o <= '0;
      ready_o  <= 1'b0;
    end else begin
      ready_o <= vld_i;
      if (vld_i) begin
        sine_o   <= fold(addr_i);
        cosine_o <= fold(cos_idx);
      end
    end
  end

  AST_READY_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i)
    vld_i |=> ready_o); // R2
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    !vld_i |=> !ready_o); // R2
  AST_SINE_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    sine_o != {1'b1, {(OUT_W-1){1'b0}}}); // R5
  AST_COS_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    cosine_o != {1'b1, {(OUT_W-1){1'b0}}}); // R5
endmodule

// File: rtl/qdds_core.sv
module qdds_core #(
  parameter int IN_W  = 32,
  parameter int PH_W  = 21,
  parameter int AW    = 10,
  parameter int OUT_W = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    tick_i,
  input  logic [IN_W-1:0]         step_i,
  output logic                    can_accept_o,
  output logic                    ready_o,
  output logic signed [OUT_W-1:0] sine_o,
  output logic signed [OUT_W-1:0] cosine_o
);
  logic [PH_W-1:0] step_q;
  logic            step_load;
  logic [AW-1:0]   lut_addr;
  logic            lut_vld;

  assign can_accept_o = 1'b1;

  qdds_step_reg #(.IN_W(IN_W), .PH_W(PH_W)) u_step (
    .clk_i(clk_i), .rst_i(rst_i), .step_i(step_i),
    .step_q(step_q), .load_o(step_load)
  );

  qdds_phase_acc #(.PH_W(PH_W), .AW(AW)) u_acc (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .step_i(step_q),
    .addr_o(lut_addr), .vld_o(lut_vld)
  );

  qdds_wave_lut #(.AW(AW), .OUT_W(OUT_W)) u_lut (
    .clk_i(clk_i), .rst_i(rst_i), .addr_i(lut_addr), .vld_i(lut_vld),
    .sine_o(sine_o), .cosine_o(cosine_o), .ready_o(ready_o)
  );

  AST_OUT_HOLD_SIN: assert property (@(posedge clk_i) disable iff (rst_i)
    !ready_o |-> $stable(sine_o)); // R3
  AST_OUT_HOLD_COS: assert property (@(posedge clk_i) disable iff (rst_i)
    !ready_o |-> $stable(cosine_o)); // R3
endmodule

// File: tb/qdds_core_tb_top.sv
module qdds_core_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        tick;
  logic [31:0] step;
  logic        can_acc, rdy;
  logic signed [19:0] sin_v, cos_v;

  int n_chk = 0;
  int n_bad = 0;
  logic [20:0] mdl_phase;
  logic [20:0] mdl_step;

  always #5 clk = ~clk;

  qdds_core dut_i (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .step_i(step),
    .can_accept_o(can_acc), .ready_o(rdy), .sine_o(sin_v), .cosine_o(cos_v)
  );

  function automatic int ideal(input logic [20:0] ph, input bit use_cos);
    real ang;
    real r;
    ang = 6.283185307179586 * real'(int'(ph[20:11])) / 1024.0;
    r = 524287.0 * (use_cos ? $cos(ang) : $sin(ang));
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_near(input string req, input int act, input int exp);
    int d;
    d = act - exp;
    check(d <= 1 && d >= -1, req, act, exp);
  endtask

  // One strobe; verifies ready timing and returns the sample pair.
  task automatic take_sample(output int s, output int c);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check(rdy == 1'b0, "R2 ready early", int'(rdy), 0);
    @(negedge clk);
    check(rdy == 1'b1, "R2 ready pulse", int'(rdy), 1);
    s = int'(sin_v); c = int'(cos_v);
    @(negedge clk);
    check(rdy == 1'b0, "R2 ready width", int'(rdy), 0);
  endtask

  task automatic sample_vs_model(input string req);
    int s, c;
    take_sample(s, c);
    check_near(req, s, ideal(mdl_phase, 1'b0));
    check_near(req, c, ideal(mdl_phase, 1'b1));
    mdl_phase = mdl_phase + mdl_step;
  endtask

  task automatic set_step(input logic [31:0] v);
    @(negedge clk); step = v;
    @(negedge clk);
    mdl_step = v[20:0];
  endtask

  task automatic t_reset();
    rst = 1'b1; tick = 1'b0; step = '0;
    repeat (3) @(negedge clk);
    check(can_acc == 1'b1, "R8 accept in reset", int'(can_acc), 1);
    rst = 1'b0;
    @(negedge clk);
    check(rdy == 1'b0, "R1 ready", int'(rdy), 0);
    check(sin_v == 0, "R1 sine", int'(sin_v), 0);
    check(cos_v == 0, "R1 cosine", int'(cos_v), 0);
    mdl_phase = '0; mdl_step = '0;
  endtask

  task automatic t_first_sample();
    int s, c;
    set_step(32'd131072);
    take_sample(s, c);
    check(s == 0, "R4 first sine", s, 0);
    check(c == 524287, "R4 first cosine", c, 524287);
    mdl_phase = mdl_phase + mdl_step;
  endtask

  task automatic t_sixteenth_steps();
    for (int i = 0; i < 17; i++) sample_vs_model("R5 R7 sixteenth-turn");
  endtask

  task automatic t_idle_hold();
    int s0, c0;
    s0 = int'(sin_v); c0 = int'(cos_v);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(rdy == 1'b0 && int'(sin_v) == s0 && int'(cos_v) == c0,
            "R3 idle hold", int'(sin_v), s0);
    end
    sample_vs_model("R3 phase kept while idle");
  endtask

  task automatic t_step_change();
    int s, c;
    // New step and strobe on the same edge: this strobe uses the old step.
    @(negedge clk); step = 32'd7919; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    s = int'(sin_v); c = int'(cos_v);
    check_near("R6 same-edge sample", s, ideal(mdl_phase, 1'b0));
    check_near("R6 same-edge sample", c, ideal(mdl_phase, 1'b1));
    mdl_phase = mdl_phase + mdl_step;
    mdl_step = 21'd7919;
    @(negedge clk);
    for (int i = 0; i < 40; i++) sample_vs_model("R6 R5 new step");
  endtask

  task automatic t_upper_bits();
    set_step(32'hFFE0_0000 | 32'd300001);
    for (int i = 0; i < 20; i++) sample_vs_model("R7 upper bits ignored");
    set_step(32'h0000_0000 | 32'd300001);
    // Same low bits: no change to the tone sequence.
    for (int i = 0; i < 10; i++) sample_vs_model("R7 low bits only");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_first_sample();
    t_sixteenth_steps();
    t_idle_hold();
    t_step_change();
    t_upper_bits();
    check(can_acc == 1'b1, "R8 accept", int'(can_acc), 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule